// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block is the interrupt unit of a small microcontroller. Four sources can raise a request: an external interrupt line, two timer overflow events and a time-base overflow. Software can also raise any request directly. Each request is held in a flag until it is serviced. A request is taken only when its own enable and the global enable are both set. The unit looks at the pending requests only on a periodic phase pulse, and the highest-priority one wins.

Once a request is accepted, the unit clears the global enable and the winning flag, so handlers do not nest. After a short, fixed entry delay it gives the CPU a one-cycle vector strobe together with the vector address. A return-from-interrupt strobe turns the global enable back on. While the core sleeps, a wake output rises as soon as an enabled request is pending. An entry accepted in that state, or while a two-cycle instruction is still running, takes one extra cycle.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, `vector_valid`, `vector` and `wake_o` are 0, and all request flags, per-source enables and the global enable are cleared. Setting every enable after reset therefore produces no vector and no wake.
- R2: A request flag latches on its event pulse whatever the enable bits are. A flag set while its source is disabled is serviced once the source is enabled.
- R3: A pending request is accepted only when its per-source enable bit and the global enable are both 1. With the global enable at 0, nothing is accepted.
- R4: Source index i has fixed priority, and index 0 (the external line) is the highest. When several enabled requests are pending, the lowest index wins and the others stay pending.
- R5: The vector for source index i is 04h + 4·i: 04h, 08h, 0Ch and 10h for indices 0 to 3.
- R6: On acceptance, the global enable and the winner's flag are cleared. No further request is accepted until the global enable is set again.
- R7: A `reti_i` pulse sets the global enable.
- R8: Pending requests are evaluated only at a clock edge where `phase_tick` is 1, using the flags latched before that edge. An event arriving in the same cycle as the pulse is serviced at the next pulse.
- R9: `vector_valid` rises exactly 2 cycles after the cycle in which the accepting `phase_tick` is high. The delay is 3 cycles if `busy_i` or `sleep_i` is 1 in that cycle.
- R10: `vector_valid` is a one-cycle pulse. `vector` keeps its value until the next vector is issued.
- R11: `wake_o` is 1 exactly when `sleep_i` is 1 and some flag with its enable set is pending, whatever the global enable is.
- R12: A `sw_set_i` bit sets the same flag as the hardware event and leads to the same acceptance and vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| phase_tick | input | 1 | Sampling phase pulse; requests are evaluated on its edges |
| evt_i | input | NUM_SRC | Hardware event pulses, index 0 = external line |
| sw_set_i | input | NUM_SRC | Software request-flag set strobes |
| en_wr_i | input | 1 | Write strobe for the per-source enables |
| en_d_i | input | NUM_SRC | Per-source enable value written on `en_wr_i` |
| gie_wr_i | input | 1 | Write strobe for the global enable |
| gie_d_i | input | 1 | Global enable value written on `gie_wr_i` |
| reti_i | input | 1 | Return-from-interrupt strobe |
| busy_i | input | 1 | A two-cycle instruction is still executing |
| sleep_i | input | 1 | Core is in sleep or idle |
| vector_valid | output | 1 | One-cycle vector strobe |
| vector | output | VEC_W | Vector address |
| wake_o | output | 1 | Wake request while sleeping |

## Verification
A flag set by an event or software pulse can first be acted on by a phase pulse in the cycle after the pulse that set it. The vector strobe then shows up in the second cycle after that phase cycle, or the third for a busy or sleeping entry. `wake_o` follows the latched flags in the cycle after they change. The bench keeps a cycle counter and records the cycle of each vector strobe at the falling edge. Each directed check compares that cycle with the phase cycle plus the expected delay. A behavioural model is also compared with all three outputs at every falling edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/intc_flags.sv
module intc_flags #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] sw_set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_d_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] flag_q, flag_n;
  logic [NUM_SRC-1:0] en_q, en_n;

  // a fresh event outranks the clear from acceptance
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_comb begin
      flag_n[g] = (flag_q[g] & ~clr_i[g]) | evt_i[g] | sw_set_i[g];
    end
  end

  always_comb begin
    en_n = en_q;
    if (en_wr_i) en_n = en_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_n;
      en_q   <= en_n;
    end
  end

  assign flags_o = flag_q;
  assign en_o    = en_q;
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int NUM_SRC = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_SRC-1:0] onehot_o
);
  logic [NUM_SRC:0] seen;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign onehot_o[g] = req_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | req_i[g];
  end

  assign any_o = seen[NUM_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/intc_seq.sv
module intc_seq
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int IDX_W    = 2,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  parameter int LAT_FAST = 2,
  parameter int LAT_SLOW = 3,
  parameter int CNT_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase_i,
  input  logic               any_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [NUM_SRC-1:0] onehot_i,
  input  logic               busy_i,
  input  logic               sleep_i,
  input  logic               reti_i,
  input  logic               gie_wr_i,
  input  logic               gie_d_i,
  output logic               accept_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic               gie_o,
  output logic               vec_valid_o,
  output logic [VEC_W-1:0]   vec_o
);
  seq_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             gie_q, gie_n;
  logic             valid_q, valid_n;
  logic [VEC_W-1:0] vec_q, vec_n;
  logic [VEC_W-1:0] pvec_q, pvec_n;
  logic             accept;
  logic [VEC_W-1:0] win_vec;

  assign win_vec = VEC_W'(VEC_BASE + VEC_STEP * int'(idx_i));
  assign accept  = phase_i & (state_q == SEQ_IDLE) & gie_q & any_i;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    valid_n = 1'b0;
    vec_n   = vec_q;
    pvec_n  = pvec_q;
    if (accept) begin
      state_n = SEQ_WAIT;
      pvec_n  = win_vec;
      cnt_n   = (busy_i | sleep_i) ? CNT_W'(LAT_SLOW - 1) : CNT_W'(LAT_FAST - 1);
    end else if (state_q == SEQ_WAIT) begin
      if (cnt_q <= CNT_W'(1)) begin
        state_n = SEQ_IDLE;
        valid_n = 1'b1;
        vec_n   = pvec_q;
        cnt_n   = '0;
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
  end

  // acceptance outranks return, return outranks a software write
  always_comb begin
    gie_n = gie_q;
    if (accept)        gie_n = 1'b0;
    else if (reti_i)   gie_n = 1'b1;
    else if (gie_wr_i) gie_n = gie_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      gie_q   <= 1'b0;
      valid_q <= 1'b0;
      vec_q   <= '0;
      pvec_q  <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      gie_q   <= gie_n;
      valid_q <= valid_n;
      vec_q   <= vec_n;
      pvec_q  <= pvec_n;
    end
  end

  assign accept_o    = accept;
  assign clr_o       = accept ? onehot_i : '0;
  assign gie_o       = gie_q;
  assign vec_valid_o = valid_q;
  assign vec_o       = vec_q;
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int NUM_SRC  = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  parameter int LAT_FAST = 2,
  parameter int LAT_SLOW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase_tick,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] sw_set_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_d_i,
  input  logic               gie_wr_i,
  input  logic               gie_d_i,
  input  logic               reti_i,
  input  logic               busy_i,
  input  logic               sleep_i,
  output logic               vector_valid,
  output logic [VEC_W-1:0]   vector,
  output logic               wake_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CNT_W = $clog2(LAT_SLOW + 1);

  logic [NUM_SRC-1:0] flags_w, en_w, clr_w, onehot_w, ready_w;
  logic               any_w, accept_w, gie_w;
  logic [IDX_W-1:0]   idx_w;

  intc_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .sw_set_i (sw_set_i),
    .clr_i    (clr_w),
    .en_wr_i  (en_wr_i),
    .en_d_i   (en_d_i),
    .flags_o  (flags_w),
    .en_o     (en_w)
  );

  assign ready_w = flags_w & en_w;

  intc_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .req_i    (ready_w),
    .any_o    (any_w),
    .idx_o    (idx_w),
    .onehot_o (onehot_w)
  );

  intc_seq #(
    .NUM_SRC (NUM_SRC),  .IDX_W   (IDX_W),    .VEC_W   (VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .LAT_FAST(LAT_FAST),
    .LAT_SLOW(LAT_SLOW), .CNT_W   (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_i     (phase_tick),
    .any_i       (any_w),
    .idx_i       (idx_w),
    .onehot_i    (onehot_w),
    .busy_i      (busy_i),
    .sleep_i     (sleep_i),
    .reti_i      (reti_i),
    .gie_wr_i    (gie_wr_i),
    .gie_d_i     (gie_d_i),
    .accept_o    (accept_w),
    .clr_o       (clr_w),
    .gie_o       (gie_w),
    .vec_valid_o (vector_valid),
    .vec_o       (vector)
  );

  assign wake_o = sleep_i & any_w;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_SRC  = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept_i,
  input logic             reti_i,
  input logic             gie_i,
  input logic             vld_i,
  input logic [VEC_W-1:0] vec_i,
  input logic             wake_i,
  input logic             sleep_i
);
  // R10: strobe lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> !vld_i);

  // R5: only legal vector addresses are issued
  a_r5_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> (int'(vec_i) >= VEC_BASE &&
               int'(vec_i) < VEC_BASE + NUM_SRC * VEC_STEP &&
               ((int'(vec_i) - VEC_BASE) % VEC_STEP) == 0));

  // R6: global enable drops after acceptance
  a_r6_gie_drop: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !gie_i);

  // R6: no back-to-back acceptance
  a_r6_no_reaccept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !accept_i);

  // R7: return strobe restores the global enable
  a_r7_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !accept_i) |=> gie_i);

  // R9: no strobe in the cycle right after acceptance
  a_r9_min_lat: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !vld_i);

  // R11: wake only while sleeping
  a_r11_wake_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |-> sleep_i);
endmodule

bind prio_vec_intc intc_chk #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept_i (accept_w),
  .reti_i   (reti_i),
  .gie_i    (gie_w),
  .vld_i    (vector_valid),
  .vec_i    (vector),
  .wake_i   (wake_o),
  .sleep_i  (sleep_i)
);

// File: tb/test_prio_vec_intc.sv
module test_prio_vec_intc;
  localparam int CLK_P = 10;

  logic       clk, rst_n, phase, en_wr, gie_wr, gie_d, reti, busy, sleep;
  logic [3:0] evt, sw, en_d;
  logic       vld, wake;
  logic [7:0] vec;

  prio_vec_intc i_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .phase_tick(phase), .evt_i(evt), .sw_set_i(sw),
    .en_wr_i(en_wr), .en_d_i(en_d), .gie_wr_i(gie_wr), .gie_d_i(gie_d),
    .reti_i(reti), .busy_i(busy), .sleep_i(sleep),
    .vector_valid(vld), .vector(vec), .wake_o(wake)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, nval = 0, last_cyc = 0;
  logic [7:0] last_vec = 8'h00;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // behavioural reference model
  logic [3:0] mf, me;
  bit         mg, mwait, mv;
  int         mcnt;
  logic [7:0] mvec, mpvec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf = '0; me = '0; mg = 0; mwait = 0; mcnt = 0; mv = 0; mvec = 0; mpvec = 0;
    end else begin
      bit acc;
      int win;
      logic [3:0] clr;
      acc = 0; win = 0; clr = '0;
      if (phase && !mwait && mg && ((mf & me) != 0)) begin
        acc = 1;
        for (int i = 3; i >= 0; i--) if (mf[i] && me[i]) win = i;
        clr[win] = 1'b1;
      end
      mv = 0;
      if (acc) begin
        mwait = 1;
        mcnt  = (busy || sleep) ? 3 : 2;
        mpvec = 8'(4 + 4 * win);
      end else if (mwait) begin
        mcnt--;
        if (mcnt == 1) begin mv = 1; mvec = mpvec; mwait = 0; end
      end
      mf = (mf & ~clr) | evt | sw;
      if (en_wr) me = en_d;
      if (acc) mg = 0; else if (reti) mg = 1; else if (gie_wr) mg = gie_d;
    end
  end

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(vld === mv, "R9 model strobe", 32'(vld), 32'(mv));
      chk(vec === mvec, "R5 model vector", 32'(vec), 32'(mvec));
      chk(wake === (sleep && ((mf & me) != 0)), "R11 model wake", 32'(wake),
          32'(sleep && ((mf & me) != 0)));
      if (vld) begin nval++; last_cyc = cyc; last_vec = vec; end
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic pulse_evt(input logic [3:0] m);
    evt = m; step(); evt = '0;
  endtask
  task automatic set_en(input logic [3:0] m);
    en_wr = 1; en_d = m; step(); en_wr = 0;
  endtask
  task automatic set_gie(input bit b);
    gie_wr = 1; gie_d = b; step(); gie_wr = 0;
  endtask
  task automatic do_reti();
    reti = 1; step(); reti = 0;
  endtask

  task automatic phase_check(input bit b_busy, input bit b_sleep, input bit hit,
                             input logic [7:0] exp_vec, input int lat, input string tag);
    int n, nv0;
    n = cyc; nv0 = nval;
    phase = 1; busy = b_busy; sleep = b_sleep;
    step();
    phase = 0; busy = 0; sleep = 0;
    repeat (5) step();
    if (hit) begin
      chk(nval == nv0 + 1, {tag, " strobe count"}, 32'(nval - nv0), 32'd1);
      chk(last_cyc == n + lat, {tag, " latency"}, 32'(last_cyc - n), 32'(lat));
      chk(last_vec == exp_vec, {tag, " vector"}, 32'(last_vec), 32'(exp_vec));
      chk(vec == exp_vec && !vld, "R10 vector held", 32'(vec), 32'(exp_vec));
    end else begin
      chk(nval == nv0, {tag, " no strobe"}, 32'(nval - nv0), 32'd0);
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 0; phase = 0; evt = 0; sw = 0; en_wr = 0; en_d = 0;
    gie_wr = 0; gie_d = 0; reti = 0; busy = 0; sleep = 0;
    repeat (3) @(posedge clk);
    #2;
    chk(vld == 0 && vec == 0 && wake == 0, "R1 reset outputs", {vld, vec}, 32'd0);
    @(posedge clk); #1; rst_n = 1;
    step();
    // R1: no stale flags after reset
    sleep = 1; set_en(4'hF); step();
    chk(wake == 0, "R1 no wake after reset", 32'(wake), 32'd0);
    sleep = 0;
    set_gie(1);
    phase_check(0, 0, 0, 8'h00, 0, "R1");
    // R3: global enable masks
    set_gie(0);
    pulse_evt(4'b0100);
    phase_check(0, 0, 0, 8'h00, 0, "R3 gie off");
    set_en(4'b0000); set_gie(1);
    phase_check(0, 0, 0, 8'h00, 0, "R3 src off");
    // R2: flag kept while disabled, serviced once enabled
    set_en(4'b0100);
    phase_check(0, 0, 1, 8'h0C, 2, "R2");
    // R6: entry cleared global enable
    set_en(4'hF);
    pulse_evt(4'b0010);
    phase_check(0, 0, 0, 8'h00, 0, "R6");
    do_reti();
    phase_check(0, 0, 1, 8'h08, 2, "R7");
    // R4 / R12: simultaneous, software sets external flag
    evt = 4'b1010; sw = 4'b0001; step(); evt = 0; sw = 0;
    do_reti();
    phase_check(0, 0, 1, 8'h04, 2, "R4 first");
    do_reti();
    phase_check(0, 0, 1, 8'h08, 2, "R4 second");
    do_reti();
    phase_check(0, 0, 1, 8'h10, 2, "R4 third");
    // R9: busy lengthens entry
    pulse_evt(4'b0001);
    do_reti();
    phase_check(1, 0, 1, 8'h04, 3, "R9 busy");
    // R11: wake only for enabled flags, independent of global enable
    pulse_evt(4'b0100);
    set_en(4'b1011);
    sleep = 1; step();
    chk(wake == 0, "R11 disabled no wake", 32'(wake), 32'd0);
    set_en(4'hF); step();
    chk(wake == 1, "R11 wake", 32'(wake), 32'd1);
    do_reti();
    phase_check(0, 1, 1, 8'h0C, 3, "R9 sleep");
    // R8: event in the pulse cycle waits for the next pulse
    do_reti();
    begin
      int nv0;
      nv0 = nval;
      evt = 4'b1000; phase = 1; step(); evt = 0; phase = 0;
      repeat (5) step();
      chk(nval == nv0, "R8 same-cycle event deferred", 32'(nval - nv0), 32'd0);
    end
    phase_check(0, 0, 1, 8'h10, 2, "R8 next pulse");
    // R12: software set alone
    do_reti();
    sw = 4'b0100; step(); sw = 0;
    phase_check(0, 0, 1, 8'h0C, 2, "R12");
    repeat (3) step();
    done = 1;
    report();
    $finish;
  end
endmodule